// File: doc/BRIEF.md
# DRAM refresh and init sequencer

This block keeps an asynchronous DRAM alive and brings it up after power is applied. Out of reset it holds every strobe inactive through a long settling pause. It then asks the access controller for the bus and runs a fixed number of warm-up cycles, each with a RAS pulse. After that it raises `init_done` and switches to periodic refresh. Every strobe cycle uses CAS-before-RAS ordering, so the DRAM's own row counter picks the row and the address pins carry nothing of interest. Write enable and output enable stay inactive throughout, and the DRAM outputs remain high-Z.

A free-running interval counter raises a refresh demand once per refresh period. A demand that cannot be served at once, because the bus has not been granted, is held in a small pending counter. Pending demands are served back to back as soon as the grant arrives. The pause, the refresh period and every strobe minimum are given as parameters in nanoseconds, together with the clock period. They are converted to whole clock cycles at elaboration: minimums round up, and the refresh period rounds down.

Top module: `dram_refresh_seq`

## Requirements
- R1: For the first C_PAUSE clocks after reset release (C_PAUSE = pause rounded up to cycles), `ras_n`, `cas_n` stay high and `bus_req`, `init_done` stay low, whatever `bus_gnt` does; `bus_req` rises on clock edge C_PAUSE.
- R2: In every strobe cycle `cas_n` falls first, and `ras_n` falls exactly C_CSR clocks later while `cas_n` is still low; `ras_n` never falls while `cas_n` is high.
- R3: `ras_n` stays low for exactly C_RAS clocks. `cas_n` returns high C_CHR clocks after `ras_n` falls, where C_CHR is the CAS hold time in cycles capped at C_RAS.
- R4: Between `ras_n` rising and the next `cas_n` fall, both strobes are high for at least C_RP clocks, the larger of the RAS and CAS precharge minimums.
- R5: During init the block issues exactly INIT_CYCLES strobe cycles. `init_done` rises on the edge where the last precharge ends and stays high until reset.
- R6: A strobe cycle starts only on a clock edge where `bus_gnt` is sampled high while `bus_req` is high.
- R7: After `init_done`, one refresh demand arises every C_REF clocks. With the grant held high, refresh cycles begin exactly C_REF clocks apart.
- R8: Up to MAX_PENDING demands wait for the grant, and further demands are dropped. Once granted, the waiting refreshes run back to back: each `cas_n` fall comes C_CSR + C_RAS + C_RP clocks after the previous one.
- R9: After `init_done`, `bus_req` is high exactly while a refresh is pending or a strobe cycle (including its precharge) is in progress. During init it is high from the end of the pause until `init_done`.
- R10: `we_n` and `oe_n` are high at all times.
- R11: Strobe minimums and the pause round up to whole cycles: 70 ns at a 20 ns clock gives a 4-clock RAS pulse. The refresh period rounds down to whole cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | output | 1 | Request for the DRAM bus from the access controller |
| bus_gnt | input | 1 | Grant from the access controller |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe shared by both bytes, active low |
| we_n | output | 1 | Write enable, held inactive |
| oe_n | output | 1 | Output enable, held inactive |
| init_done | output | 1 | High once the power-up sequence has finished |

## Verification
The properties assume the access controller keeps `bus_gnt` high for as long as `bus_req` is high once it has granted. Withdrawing the grant in the middle of a strobe cycle would leave a cycle that no longer matches the request. The stimulus respects this. While tracking the request it grants only when `bus_req` is high. When it withholds the grant, it lets an existing grant fall only after `bus_req` has dropped. The bench also raises the grant during the power-up pause, with no request outstanding, to show that such a grant is ignored.

// File: rtl/dram_refresh_pkg.sv
`timescale 1ns/1ps
package dram_refresh_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_PRECHG = 2'd3
    } strobe_phase_e;

    typedef enum logic [1:0] {
        MODE_PAUSE = 2'd0,
        MODE_INIT  = 2'd1,
        MODE_RUN   = 2'd2
    } seq_mode_e;

    // minimum durations: round up, never below one cycle
    function automatic int unsigned cycles_at_least(input int unsigned ns, input int unsigned clk_ps);
        longint unsigned ps;
        longint unsigned c;
        ps = longint'(ns) * 1000;
        c  = (ps + longint'(clk_ps) - 1) / longint'(clk_ps);
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    // maximum intervals: round down, never below one cycle
    function automatic int unsigned cycles_at_most(input int unsigned ns, input int unsigned clk_ps);
        longint unsigned c;
        c = (longint'(ns) * 1000) / longint'(clk_ps);
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/dram_strobe_engine.sv
`timescale 1ns/1ps
module dram_strobe_engine
    import dram_refresh_pkg::*;
#(
    parameter int unsigned C_SETUP  = 1,
    parameter int unsigned C_ACTIVE = 3,
    parameter int unsigned C_HOLD   = 1,
    parameter int unsigned C_PRECHG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o,
    output logic busy_o,
    output logic ras_n_o,
    output logic cas_n_o
);

    localparam int unsigned C_MAX_A = (C_SETUP > C_ACTIVE) ? C_SETUP : C_ACTIVE;
    localparam int unsigned C_MAX   = (C_MAX_A > C_PRECHG) ? C_MAX_A : C_PRECHG;
    localparam int unsigned CW      = $clog2(C_MAX + 1);

    typedef struct packed {
        strobe_phase_e   phase;
        logic [CW-1:0]   cnt;
    } eng_state_t;

    eng_state_t st_d, st_q;
    logic [CW-1:0] len_m1;
    logic          last;

    always_comb begin
        case (st_q.phase)
            PH_SETUP:  len_m1 = CW'(C_SETUP - 1);
            PH_ACTIVE: len_m1 = CW'(C_ACTIVE - 1);
            PH_PRECHG: len_m1 = CW'(C_PRECHG - 1);
            default:   len_m1 = '0;
        endcase
        last = (st_q.cnt == len_m1);

        st_d = st_q;
        case (st_q.phase)
            PH_SETUP: begin
                if (last) begin
                    st_d.phase = PH_ACTIVE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_ACTIVE: begin
                if (last) begin
                    st_d.phase = PH_PRECHG;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            PH_PRECHG: begin
                if (last) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
            end
            default: st_d = st_q;
        endcase

        // a new cycle may follow the final precharge clock directly
        ready_o = (st_q.phase == PH_IDLE) || ((st_q.phase == PH_PRECHG) && last);
        if (ready_o && start_i) begin
            st_d.phase = PH_SETUP;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.phase != PH_IDLE);
    assign ras_n_o = (st_q.phase != PH_ACTIVE);
    assign cas_n_o = !((st_q.phase == PH_SETUP) ||
                       ((st_q.phase == PH_ACTIVE) && (st_q.cnt < CW'(C_HOLD))));

endmodule

// File: rtl/dram_refresh_timer.sv
`timescale 1ns/1ps
module dram_refresh_timer #(
    parameter int unsigned C_INTERVAL  = 781,
    parameter int unsigned MAX_PENDING = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic take_i,
    output logic pend_any_o
);

    localparam int unsigned TW = $clog2(C_INTERVAL + 1);
    localparam int unsigned PW = $clog2(MAX_PENDING + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [PW-1:0] pend;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic tick;
    logic inc;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        inc  = 1'b0;
        if (!en_i) begin
            st_d.tmr  = '0;
            st_d.pend = '0;
        end else begin
            tick     = (st_q.tmr == TW'(C_INTERVAL - 1));
            st_d.tmr = tick ? '0 : st_q.tmr + TW'(1);
            // a full counter keeps its value only when one leaves at the same time
            inc = tick && ((st_q.pend < PW'(MAX_PENDING)) || take_i);
            if (inc && !take_i)      st_d.pend = st_q.pend + PW'(1);
            else if (!inc && take_i) st_d.pend = st_q.pend - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tmr  <= '0;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_any_o = (st_q.pend != '0);

endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
module dram_refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int unsigned CLK_PS      = 20000,
    parameter int unsigned PAUSE_NS    = 200000,
    parameter int unsigned REFRESH_NS  = 15625,
    parameter int unsigned TRAS_NS     = 60,
    parameter int unsigned TRP_NS      = 40,
    parameter int unsigned TCP_NS      = 10,
    parameter int unsigned TCSR_NS     = 10,
    parameter int unsigned TCHR_NS     = 10,
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned MAX_PENDING = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic bus_req,
    input  logic bus_gnt,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic oe_n,
    output logic init_done
);

    localparam int unsigned C_PAUSE_CYC = cycles_at_least(PAUSE_NS, CLK_PS);
    localparam int unsigned C_REF_CYC   = cycles_at_most(REFRESH_NS, CLK_PS);
    localparam int unsigned C_RAS_CYC   = cycles_at_least(TRAS_NS, CLK_PS);
    localparam int unsigned C_RPR_CYC   = cycles_at_least(TRP_NS, CLK_PS);
    localparam int unsigned C_CPR_CYC   = cycles_at_least(TCP_NS, CLK_PS);
    localparam int unsigned C_RP_CYC    = (C_RPR_CYC > C_CPR_CYC) ? C_RPR_CYC : C_CPR_CYC;
    localparam int unsigned C_CSR_CYC   = cycles_at_least(TCSR_NS, CLK_PS);
    localparam int unsigned C_CHR_RAW   = cycles_at_least(TCHR_NS, CLK_PS);
    localparam int unsigned C_CHR_CYC   = (C_CHR_RAW > C_RAS_CYC) ? C_RAS_CYC : C_CHR_RAW;
    localparam int unsigned PCW         = $clog2(C_PAUSE_CYC + 1);
    localparam int unsigned SW          = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        seq_mode_e      mode;
        logic [PCW-1:0] pause_cnt;
        logic [SW-1:0]  started;
        logic           done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic eng_start;
    logic eng_ready;
    logic eng_busy;
    logic run_take;
    logic pend_any;

    dram_strobe_engine #(
        .C_SETUP  (C_CSR_CYC),
        .C_ACTIVE (C_RAS_CYC),
        .C_HOLD   (C_CHR_CYC),
        .C_PRECHG (C_RP_CYC)
    ) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .ready_o (eng_ready),
        .busy_o  (eng_busy),
        .ras_n_o (ras_n),
        .cas_n_o (cas_n)
    );

    dram_refresh_timer #(
        .C_INTERVAL  (C_REF_CYC),
        .MAX_PENDING (MAX_PENDING)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (st_q.mode == MODE_RUN),
        .take_i     (run_take),
        .pend_any_o (pend_any)
    );

    always_comb begin
        st_d      = st_q;
        eng_start = 1'b0;
        run_take  = 1'b0;
        case (st_q.mode)
            MODE_PAUSE: begin
                if (st_q.pause_cnt == PCW'(C_PAUSE_CYC - 1)) begin
                    st_d.mode      = MODE_INIT;
                    st_d.pause_cnt = '0;
                end else begin
                    st_d.pause_cnt = st_q.pause_cnt + PCW'(1);
                end
            end
            MODE_INIT: begin
                if (eng_ready && (st_q.started == SW'(INIT_CYCLES))) begin
                    st_d.mode = MODE_RUN;
                    st_d.done = 1'b1;
                end else if (bus_gnt && eng_ready && (st_q.started < SW'(INIT_CYCLES))) begin
                    eng_start    = 1'b1;
                    st_d.started = st_q.started + SW'(1);
                end
            end
            MODE_RUN: begin
                if (bus_gnt && eng_ready && pend_any) begin
                    eng_start = 1'b1;
                    run_take  = 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode      <= MODE_PAUSE;
            st_q.pause_cnt <= '0;
            st_q.started   <= '0;
            st_q.done      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_req   = (st_q.mode == MODE_INIT) ||
                       ((st_q.mode == MODE_RUN) && (pend_any || eng_busy));
    assign init_done = st_q.done;
    assign we_n      = 1'b1;
    assign oe_n      = 1'b1;

endmodule

// File: rtl/dram_refresh_seq_chk.sv
`timescale 1ns/1ps
module dram_refresh_seq_chk #(
    parameter int unsigned C_RAS = 3,
    parameter int unsigned C_RP  = 2
) (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_gnt,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic oe_n,
    input logic init_done
);

    int unsigned ras_low_len;
    int unsigned both_high_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_low_len   <= 0;
            both_high_len <= C_RP;
        end else begin
            ras_low_len <= ras_n ? 0 : ras_low_len + 1;
            if (ras_n && cas_n)
                both_high_len <= (both_high_len < C_RP) ? both_high_len + 1 : both_high_len;
            else
                both_high_len <= 0;
        end
    end

    AST_RAS_FALL_CAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !cas_n); // R2

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n)); // R2

    AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (ras_low_len == C_RAS)); // R3

    AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> (both_high_len >= C_RP)); // R4

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R5

    AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> ($past(bus_gnt) && $past(bus_req))); // R6

    AST_QUIET_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !bus_req) |-> (ras_n && cas_n)); // R1

    AST_NO_DATA_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        we_n && oe_n); // R10

endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
    .C_RAS (C_RAS_CYC),
    .C_RP  (C_RP_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .init_done (init_done)
);

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;

    localparam int CLK_PS   = 20000;
    localparam int PAUSE_NS = 4000;
    localparam int REF_NS   = 2000;
    localparam int TRAS_NS  = 70;
    localparam int TRP_NS   = 50;
    localparam int TCP_NS   = 10;
    localparam int TCSR_NS  = 10;
    localparam int TCHR_NS  = 25;
    localparam int INIT_N   = 8;
    localparam int MAXP     = 4;

    // expected cycle counts, worked out from the requirements
    localparam int E_PAUSE = (PAUSE_NS * 1000 + CLK_PS - 1) / CLK_PS;   // 200
    localparam int E_REF   = (REF_NS * 1000) / CLK_PS;                  // 100
    localparam int E_RAS   = 4;                                         // 70 ns rounded up
    localparam int E_CSR   = 1;
    localparam int E_CHR   = 2;
    localparam int E_RP    = 3;
    localparam int E_SPAN  = E_CSR + E_RAS + E_RP;

    localparam int T_PAUSE_GNT = 100;
    localparam int T_INIT_GNT  = 210;
    localparam int T_BLOCK     = 800;
    localparam int T_RELEASE   = 1300;
    localparam int T_END       = 2000;

    logic clk = 1'b0;
    logic rst_n;
    logic bus_gnt;
    logic bus_req, ras_n, cas_n, we_n, oe_n, init_done;

    always #10 clk = ~clk;

    dram_refresh_seq #(
        .CLK_PS (CLK_PS), .PAUSE_NS (PAUSE_NS), .REFRESH_NS (REF_NS),
        .TRAS_NS (TRAS_NS), .TRP_NS (TRP_NS), .TCP_NS (TCP_NS),
        .TCSR_NS (TCSR_NS), .TCHR_NS (TCHR_NS),
        .INIT_CYCLES (INIT_N), .MAX_PENDING (MAXP)
    ) uut (
        .clk (clk), .rst_n (rst_n), .bus_req (bus_req), .bus_gnt (bus_gnt),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .oe_n (oe_n),
        .init_done (init_done)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    bit [1:0] wave[$];   // {ras_n, cas_n} per upcoming clock
    int m_mode, m_pcnt, m_started, m_tmr, m_pend;
    bit m_done;
    bit e_ras, e_cas, e_req, e_done;

    task automatic push_cycle();
        for (int i = 0; i < E_CSR; i++) wave.push_back(2'b10);
        for (int i = 0; i < E_RAS; i++) wave.push_back({1'b0, (i < E_CHR) ? 1'b0 : 1'b1});
        for (int i = 0; i < E_RP; i++)  wave.push_back(2'b11);
    endtask

    task automatic model_step(input bit g);
        bit rdy, tick, go;
        if (wave.size() > 0) void'(wave.pop_front());
        rdy = (wave.size() == 0);
        case (m_mode)
            0: begin
                m_pcnt++;
                if (m_pcnt == E_PAUSE) m_mode = 1;
            end
            1: begin
                if (rdy && m_started == INIT_N) begin
                    m_mode = 2; m_done = 1; m_tmr = 0; m_pend = 0;
                end else if (g && rdy && m_started < INIT_N) begin
                    push_cycle();
                    m_started++;
                end
            end
            default: begin
                tick  = (m_tmr == E_REF - 1);
                m_tmr = tick ? 0 : m_tmr + 1;
                go    = g && (m_pend > 0) && rdy;
                if (tick && (m_pend < MAXP || go)) m_pend++;
                if (go) begin
                    m_pend--;
                    push_cycle();
                end
            end
        endcase
        e_ras  = (wave.size() > 0) ? wave[0][1] : 1'b1;
        e_cas  = (wave.size() > 0) ? wave[0][0] : 1'b1;
        e_req  = (m_mode == 1) || (m_mode == 2 && (m_pend > 0 || wave.size() > 0));
        e_done = m_done;
    endtask

    function automatic bit grant_for(input int e, input bit req, input bit cur);
        if (e >= T_PAUSE_GNT && e < T_PAUSE_GNT + 10) return 1'b1;
        if (e < T_INIT_GNT) return 1'b0;
        if (e < T_BLOCK)    return req;
        if (e < T_RELEASE)  return cur && req;
        return 1'b1;
    endfunction

    initial begin
        int ras_falls_init = 0;
        int burst_falls = 0;
        int last_cas_fall = -1;
        int last_ras_fall = -1;
        int last_ras_rise = -1;
        int last_steady = -1;
        int early_falls = 0;
        bit prev_ras = 1'b1, prev_cas = 1'b1, prev_gnt = 1'b0, done_seen = 1'b0;
        bit g;

        rst_n   = 1'b0;
        bus_gnt = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ras_n && cas_n, "R1", "strobes in reset", {ras_n, cas_n}, 3);
        check(!bus_req && !init_done, "R1", "req/done in reset", {bus_req, init_done}, 0);

        m_mode = 0; m_pcnt = 0; m_started = 0; m_tmr = 0; m_pend = 0; m_done = 0;
        rst_n = 1'b1;
        model_step(1'b0);

        for (int e = 2; e <= T_END; e++) begin
            @(negedge clk);
            // cycle-by-cycle comparison against the model
            check(ras_n == e_ras, "R3", "ras_n", ras_n, e_ras);
            check(cas_n == e_cas, "R3", "cas_n", cas_n, e_cas);
            check(bus_req == e_req, "R9", "bus_req", bus_req, e_req);
            check(init_done == e_done, "R5", "init_done", init_done, e_done);
            check(we_n && oe_n, "R10", "we_n/oe_n", {we_n, oe_n}, 3);

            // port-level timing measurements; last edge was e-1
            if (prev_cas && !cas_n) begin
                // R6: the start edge sampled the grant driven on the previous step
                check(prev_gnt, "R6", "cycle started without grant", prev_gnt, 1);
                if (e - 1 < T_INIT_GNT) early_falls++;
                if (last_ras_rise >= 0)
                    check(e - 1 - last_ras_rise >= E_RP, "R4", "precharge clocks",
                          e - 1 - last_ras_rise, E_RP);
                if (e - 1 >= T_RELEASE && e - 1 < T_RELEASE + 40) begin
                    burst_falls++;
                    if (burst_falls > 1)
                        check(e - 1 - last_cas_fall == E_SPAN, "R8", "back-to-back spacing",
                              e - 1 - last_cas_fall, E_SPAN);
                end
                if (e - 1 > T_RELEASE + 50) begin
                    if (last_steady >= 0)
                        check(e - 1 - last_steady == E_REF, "R7", "refresh interval",
                              e - 1 - last_steady, E_REF);
                    last_steady = e - 1;
                end
                last_cas_fall = e - 1;
            end
            if (prev_ras && !ras_n) begin
                check(!cas_n, "R2", "cas low at ras fall", cas_n, 0);
                check(e - 1 - last_cas_fall == E_CSR, "R2", "cas-to-ras setup",
                      e - 1 - last_cas_fall, E_CSR);
                if (!done_seen) ras_falls_init++;
                last_ras_fall = e - 1;
            end
            if (!prev_ras && ras_n) begin
                // R11: 70 ns at 20 ns rounds up to 4 clocks
                check(e - 1 - last_ras_fall == E_RAS, "R11", "ras low clocks",
                      e - 1 - last_ras_fall, E_RAS);
                last_ras_rise = e - 1;
            end
            if (init_done) done_seen = 1'b1;
            prev_ras = ras_n;
            prev_cas = cas_n;

            g = grant_for(e, bus_req, bus_gnt);
            bus_gnt  = g;
            prev_gnt = g;
            model_step(g);
        end

        check(early_falls == 0, "R1", "strobe cycles before init grant", early_falls, 0);
        check(ras_falls_init == INIT_N, "R5", "init ras pulses", ras_falls_init, INIT_N);
        check(burst_falls == MAXP, "R8", "refreshes after held grant", burst_falls, MAXP);
        check(last_steady >= 0, "R7", "steady refreshes seen", last_steady >= 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule